// File: doc/BRIEF.md
# Failure-Flag NMI Supervisor with Escalation Counter

This block watches a small set of hardware failure inputs, one of which is a clock-fail detect. A failure input that goes high for at least one clock cycle sets a sticky flag. While any flag that is enabled by the `EN_MASK` parameter is pending, the block drives a non-maskable interrupt request. It also runs an up-counter that measures how long the failure has gone unserviced. Software normally services the interrupt and clears the flag with a write-1-to-clear register. If the counter instead reaches a programmable period, the block fires a one-cycle system reset strobe. The counter then wraps to zero and keeps counting while the failure is still pending.

For bring-up and self-test, software can raise the clock-fail flag through a force register. That lets the whole interrupt and escalation path be exercised without a real clock fault. Writes to the force register and to the period register are accepted only while the protected-write enable input is high. Registers sit on a simple single-cycle bus: a write strobe, an address and write data. The read data is a combinational function of the address.

Top module: `nmi_supervisor`

## Requirements
- R1: After a synchronous active-low reset, all flags are 0, the counter is 0, the period is 0xFFFF, `nmi_o` is 0 and `rst_strobe_o` is 0.
- R2: A high level on `fail_i[k]` at a clock edge sets flag k. Flag k reads at bit k+1 of the flag register (address 0): bit 1 is clock-fail and bit 2 is the second failure. The flag stays set after the input falls, until it is cleared.
- R3: `nmi_o` and bit 0 of the flag register are 1 exactly while a flag enabled in `EN_MASK` is set (default: only clock-fail). A disabled flag is still latched and readable, but it raises no interrupt and does not run the counter.
- R4: While an enabled flag is pending, the counter (address 4) increases by one per clock. Otherwise it is 0 and held at 0.
- R5: On the clock edge after the counter equals the period (address 3), the counter returns to 0 and `rst_strobe_o` is high for exactly one cycle, provided the period is nonzero. Counting then restarts if the failure is still pending.
- R6: Writing 1 to bit k+1 of the clear register (address 1) clears flag k, and writing 0 there has no effect. A failure input or force in the same cycle wins over the clear. After the last enabled flag is cleared, the counter reads 0 one cycle later.
- R7: With `prot_en_i` high, writing 1 to bit 1 of the force register (address 2) sets the clock-fail flag. Writing 0 there changes nothing, and the force register always reads 0.
- R8: With `prot_en_i` low, writes to the force and period registers are ignored.
- R9: The period register reads back the last protected write. The flag and counter registers are read-only, so writes to addresses 0 and 4 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fail_i | input | NUM_FAIL | Hardware failure inputs; bit 0 is clock-fail |
| prot_en_i | input | 1 | Protected-register write enable |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | DATA_W | Register write data |
| rdata_o | output | DATA_W | Register read data for `addr_i` |
| nmi_o | output | 1 | Non-maskable interrupt request |
| rst_strobe_o | output | 1 | One-cycle system reset request |

## Verification
A failure input, a force write or a clear write shows in the flag register and on `nmi_o` after the clock edge that samples it. The counter reads N after N edges of pending failure. The reset strobe appears on the edge after the counter reads the period value. The bench drives inputs 2 ns after a rising edge. It advances a behavioural model on every rising edge and compares `nmi_o`, `rst_strobe_o` and the read data at each falling edge, so every result is sampled in the cycle it is due. Directed reads placed right after each stimulus edge pin down those same latencies for the individual requirements.

// File: rtl/nmi_sup_pkg.sv
// Package: shared register map and widths for the NMI supervisor.
// Assumes a 3-bit word address bus; all other widths are parameters of the modules.
package nmi_sup_pkg;

    localparam int NMI_ADDR_W = 3;

    typedef enum logic [NMI_ADDR_W-1:0] {
        REG_FLAGS  = 3'd0,
        REG_CLEAR  = 3'd1,
        REG_FORCE  = 3'd2,
        REG_PERIOD = 3'd3,
        REG_COUNT  = 3'd4
    } nmi_reg_e;

endpackage

// File: rtl/nmi_flag_bank.sv
// Module: nmi_flag_bank
// Holds one sticky flag per failure source. A set (hardware input or force)
// beats a clear in the same cycle. Drives the pending summary for enabled flags.
// Assumes force_i and clr_i are already decoded single-cycle pulses.
module nmi_flag_bank #(
    parameter int                    NUM_FAIL = 2,
    parameter logic [NUM_FAIL-1:0]   EN_MASK  = NUM_FAIL'(1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_FAIL-1:0] fail_i,
    input  logic [NUM_FAIL-1:0] force_i,
    input  logic [NUM_FAIL-1:0] clr_i,
    output logic [NUM_FAIL-1:0] flags_o,
    output logic                pending_o
);

    logic [NUM_FAIL-1:0] set_vec;
    logic [NUM_FAIL-1:0] flag_q;

    // Combine hardware and software set requests.
    always_comb begin
        set_vec = fail_i | force_i;
    end

    // One sticky flag flop per failure source.
    for (genvar gi = 0; gi < NUM_FAIL; gi++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flag_q[gi] <= 1'b0;
            end else if (set_vec[gi]) begin
                flag_q[gi] <= 1'b1;
            end else if (clr_i[gi]) begin
                flag_q[gi] <= 1'b0;
            end
        end
    end

    // Summary of enabled pending failures.
    always_comb begin
        flags_o   = flag_q;
        pending_o = |(flag_q & EN_MASK);
    end

    // R2: a set flag that was not cleared stays set.
    a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ((flag_q & $past(flag_q & ~clr_i)) == $past(flag_q & ~clr_i)));

    // R6: a clear without a concurrent set empties the flag.
    a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ((flag_q & $past(clr_i & ~set_vec)) == '0));

    // R2: a set request always leaves the flag set.
    a_r2_set: assert property (@(posedge clk) disable iff (!rst_n)
        ((flag_q & $past(set_vec)) == $past(set_vec)));

endmodule

// File: rtl/nmi_wdog_counter.sv
// Module: nmi_wdog_counter
// Escalation counter: counts clocks while a failure is pending, wraps at the
// period and emits a registered one-cycle reset strobe on the wrap.
// Assumes pending_i and period_i come from registers (no combinational loops).
module nmi_wdog_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pending_i,
    input  logic [CNT_W-1:0] period_i,
    output logic [CNT_W-1:0] count_o,
    output logic             strobe_o
);

    logic [CNT_W-1:0] cnt_q;
    logic             strobe_q;
    logic             hit;

    // Detect that the counter has arrived at the programmed period.
    always_comb begin
        hit = (cnt_q == period_i);
    end

    // Count while pending, hold at zero otherwise, wrap and strobe on a hit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            strobe_q <= 1'b0;
        end else begin
            strobe_q <= pending_i & hit;
            if (!pending_i || hit) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    // Drive outputs from the state flops.
    always_comb begin
        count_o  = cnt_q;
        strobe_o = strobe_q;
    end

    // R4: no pending failure forces the counter to zero next cycle.
    a_r4_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !pending_i |=> (cnt_q == '0));

    // R4: below the period the counter steps by one.
    a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
        (pending_i && (cnt_q != period_i)) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

    // R5: reaching the period fires the strobe and wraps to zero.
    a_r5_fire: assert property (@(posedge clk) disable iff (!rst_n)
        (pending_i && (cnt_q == period_i)) |=> (strobe_q && (cnt_q == '0)));

    // R5: with a nonzero period the strobe lasts one cycle.
    a_r5_single: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_q && (period_i != '0)) |=> !strobe_q);

endmodule

// File: rtl/nmi_reg_if.sv
// Module: nmi_reg_if
// Register decode: write-1-to-clear and force pulses, the protected period
// register, and the combinational read mux. Assumes DATA_W > NUM_FAIL and
// DATA_W == CNT_W so each register maps to one word.
module nmi_reg_if
    import nmi_sup_pkg::*;
#(
    parameter int               NUM_FAIL   = 2,
    parameter int               CNT_W      = 16,
    parameter int               DATA_W     = 16,
    parameter logic [CNT_W-1:0] PERIOD_RST = '1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_i,
    input  logic [NMI_ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0]     wdata_i,
    input  logic                  prot_en_i,
    input  logic [NUM_FAIL-1:0]   flags_i,
    input  logic                  pending_i,
    input  logic [CNT_W-1:0]      count_i,
    output logic [NUM_FAIL-1:0]   clr_o,
    output logic [NUM_FAIL-1:0]   force_o,
    output logic [CNT_W-1:0]      period_o,
    output logic [DATA_W-1:0]     rdata_o
);

    logic [CNT_W-1:0]    period_q;
    logic                wr_clear;
    logic                wr_force;
    logic                wr_period;
    logic [NUM_FAIL-1:0] field;

    // Decode write targets; force and period need the protect enable.
    always_comb begin
        wr_clear  = wr_i && (addr_i == REG_CLEAR);
        wr_force  = wr_i && prot_en_i && (addr_i == REG_FORCE);
        wr_period = wr_i && prot_en_i && (addr_i == REG_PERIOD);
        field     = wdata_i[NUM_FAIL:1];
    end

    // Per-flag clear and force pulses.
    always_comb begin
        clr_o   = wr_clear ? field : '0;
        force_o = wr_force ? field : '0;
    end

    // Period register, loaded by a protected write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period_q <= PERIOD_RST;
        end else if (wr_period) begin
            period_q <= wdata_i[CNT_W-1:0];
        end
    end

    // Read mux; write-only registers return zero.
    always_comb begin
        rdata_o = '0;
        unique case (addr_i)
            REG_FLAGS: begin
                rdata_o[NUM_FAIL:1] = flags_i;
                rdata_o[0]          = pending_i;
            end
            REG_PERIOD: rdata_o[CNT_W-1:0] = period_q;
            REG_COUNT:  rdata_o[CNT_W-1:0] = count_i;
            default:    rdata_o = '0;
        endcase
    end

    // Expose the period to the counter.
    always_comb begin
        period_o = period_q;
    end

    // R8: an unprotected write never alters the period.
    a_r8_period_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !prot_en_i) |=> $stable(period_q));

    // R9: a protected period write is read back as written.
    a_r9_period_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && prot_en_i && (addr_i == REG_PERIOD)) |=> (period_q == $past(wdata_i[CNT_W-1:0])));

endmodule

// File: rtl/nmi_supervisor.sv
// Module: nmi_supervisor (top)
// Failure-flag NMI supervisor: sticky failure flags, interrupt request,
// escalation counter and one-cycle reset strobe behind a small register bus.
// Assumes fail_i is synchronous to clk; fail_i[0] is the clock-fail source.
module nmi_supervisor
    import nmi_sup_pkg::*;
#(
    parameter int                  NUM_FAIL   = 2,
    parameter logic [NUM_FAIL-1:0] EN_MASK    = NUM_FAIL'(1),
    parameter int                  CNT_W      = 16,
    parameter int                  DATA_W     = 16,
    parameter logic [CNT_W-1:0]    PERIOD_RST = '1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_FAIL-1:0]   fail_i,
    input  logic                  prot_en_i,
    input  logic                  wr_i,
    input  logic [NMI_ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0]     wdata_i,
    output logic [DATA_W-1:0]     rdata_o,
    output logic                  nmi_o,
    output logic                  rst_strobe_o
);

    logic [NUM_FAIL-1:0] flags_w;
    logic [NUM_FAIL-1:0] clr_w;
    logic [NUM_FAIL-1:0] force_w;
    logic                pending_w;
    logic [CNT_W-1:0]    period_w;
    logic [CNT_W-1:0]    count_w;
    logic                strobe_w;

    nmi_reg_if #(
        .NUM_FAIL   (NUM_FAIL),
        .CNT_W      (CNT_W),
        .DATA_W     (DATA_W),
        .PERIOD_RST (PERIOD_RST)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (wr_i),
        .addr_i    (addr_i),
        .wdata_i   (wdata_i),
        .prot_en_i (prot_en_i),
        .flags_i   (flags_w),
        .pending_i (pending_w),
        .count_i   (count_w),
        .clr_o     (clr_w),
        .force_o   (force_w),
        .period_o  (period_w),
        .rdata_o   (rdata_o)
    );

    nmi_flag_bank #(
        .NUM_FAIL (NUM_FAIL),
        .EN_MASK  (EN_MASK)
    ) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .fail_i    (fail_i),
        .force_i   (force_w),
        .clr_i     (clr_w),
        .flags_o   (flags_w),
        .pending_o (pending_w)
    );

    nmi_wdog_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .pending_i (pending_w),
        .period_i  (period_w),
        .count_o   (count_w),
        .strobe_o  (strobe_w)
    );

    // Drive the interrupt and reset request outputs.
    always_comb begin
        nmi_o        = pending_w;
        rst_strobe_o = strobe_w;
    end

    // R7: a protected force of bit 1 raises the clock-fail flag.
    a_r7_force_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && prot_en_i && (addr_i == REG_FORCE) && wdata_i[1]) |=> flags_w[0]);

    // R3: the interrupt line follows enabled pending flags only.
    a_r3_nmi_mask: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_o |-> ((flags_w & EN_MASK) != '0));

endmodule

// File: tb/nmi_supervisor_bench.sv
// Bench: behavioural model advanced on each rising edge, outputs compared on
// each falling edge, plus directed reads after each stimulus.
module nmi_supervisor_bench;
    import nmi_sup_pkg::*;

    localparam logic [1:0] MASK = 2'b01;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  fail_i = '0;
    logic        prot_en_i = 1'b0;
    logic        wr_i = 1'b0;
    logic [2:0]  addr_i = '0;
    logic [15:0] wdata_i = '0;
    logic [15:0] rdata_o;
    logic        nmi_o;
    logic        rst_strobe_o;

    int    n_chk = 0;
    int    n_bad = 0;
    bit    started = 0;
    bit    done = 0;
    string cur_req = "R1";

    // Model state
    logic [1:0] m_flags = '0;
    int         m_cnt = 0;
    int         m_per = 16'hFFFF;
    bit         m_strobe = 0;

    always #5 clk = ~clk;

    nmi_supervisor u_nmi_supervisor (
        .clk          (clk),
        .rst_n        (rst_n),
        .fail_i       (fail_i),
        .prot_en_i    (prot_en_i),
        .wr_i         (wr_i),
        .addr_i       (addr_i),
        .wdata_i      (wdata_i),
        .rdata_o      (rdata_o),
        .nmi_o        (nmi_o),
        .rst_strobe_o (rst_strobe_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic bit m_pend();
        return |(m_flags & MASK);
    endfunction

    function automatic int m_read(input logic [2:0] a);
        case (a)
            3'd0: return {m_flags, m_pend()};
            3'd3: return m_per;
            3'd4: return m_cnt;
            default: return 0;
        endcase
    endfunction

    // Reference model step on each rising edge.
    always @(posedge clk) begin
        logic [1:0] set_v, clr_v;
        bit         p;
        started = 1;
        if (!rst_n) begin
            m_flags = '0; m_cnt = 0; m_per = 16'hFFFF; m_strobe = 0;
        end else begin
            p = m_pend();
            m_strobe = p && (m_cnt == m_per);
            if (!p || m_cnt == m_per) m_cnt = 0; else m_cnt = m_cnt + 1;
            set_v = fail_i;
            if (wr_i && prot_en_i && addr_i == 3'd2) set_v = set_v | wdata_i[2:1];
            clr_v = (wr_i && addr_i == 3'd1) ? wdata_i[2:1] : 2'b00;
            m_flags = (m_flags & ~clr_v) | set_v;
            if (wr_i && prot_en_i && addr_i == 3'd3) m_per = wdata_i;
        end
    end

    // Continuous comparison on every falling edge.
    always @(negedge clk) begin
        if (started && !done) begin
            chk(cur_req, "nmi_o", nmi_o, m_pend());
            chk(cur_req, "rst_strobe_o", rst_strobe_o, m_strobe);
            chk(cur_req, "rdata_o", rdata_o, m_read(addr_i));
        end
    end

    task automatic step(input int n);
        repeat (n) begin
            @(posedge clk);
            #2;
        end
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [15:0] d, input bit prot);
        addr_i = a; wdata_i = d; prot_en_i = prot; wr_i = 1'b1;
        step(1);
        wr_i = 1'b0; prot_en_i = 1'b0; wdata_i = '0;
    endtask

    task automatic rd(input logic [2:0] a, output int v);
        addr_i = a;
        #1;
        v = rdata_o;
    endtask

    initial begin
        int v;
        step(3);
        // R1 reset values
        cur_req = "R1";
        rd(3'd0, v); chk("R1", "flags", v, 0);
        rd(3'd3, v); chk("R1", "period", v, 16'hFFFF);
        rd(3'd4, v); chk("R1", "count", v, 0);
        chk("R1", "nmi_o", nmi_o, 0);
        rst_n = 1'b1;
        step(1);
        rd(3'd4, v); chk("R1", "count after release", v, 0);

        // R9 period load and read-only registers
        cur_req = "R9";
        wr_reg(3'd3, 16'd5, 1);
        rd(3'd3, v); chk("R9", "period readback", v, 5);
        wr_reg(3'd4, 16'h0007, 1);
        rd(3'd4, v); chk("R9", "count read-only", v, 0);
        wr_reg(3'd0, 16'h0006, 1);
        rd(3'd0, v); chk("R9", "flags read-only", v, 0);

        // R8 protected writes ignored without enable
        cur_req = "R8";
        wr_reg(3'd3, 16'd9, 0);
        rd(3'd3, v); chk("R8", "period locked", v, 5);
        wr_reg(3'd2, 16'h0002, 0);
        rd(3'd0, v); chk("R8", "force locked", v, 0);

        // R2/R3 disabled flag latches but raises nothing
        cur_req = "R3";
        fail_i = 2'b10; step(1); fail_i = 2'b00;
        rd(3'd0, v); chk("R2", "second flag latched at bit 2", v, 4);
        chk("R3", "nmi_o disabled flag", nmi_o, 0);
        step(3);
        rd(3'd4, v); chk("R3", "count idle for disabled flag", v, 0);
        rd(3'd0, v); chk("R2", "flag sticky", v, 4);
        wr_reg(3'd1, 16'h0004, 0);
        rd(3'd0, v); chk("R6", "second flag cleared", v, 0);

        // R4/R5 clock-fail escalation
        cur_req = "R4";
        fail_i = 2'b01; step(1); fail_i = 2'b00;
        rd(3'd0, v); chk("R2", "clock-fail at bit 1 with summary", v, 3);
        chk("R3", "nmi_o raised", nmi_o, 1);
        rd(3'd4, v); chk("R4", "count start", v, 0);
        step(3);
        rd(3'd4, v); chk("R4", "count after 3", v, 3);
        cur_req = "R5";
        step(2);
        rd(3'd4, v); chk("R5", "count at period", v, 5);
        chk("R5", "no strobe yet", rst_strobe_o, 0);
        step(1);
        chk("R5", "strobe fires", rst_strobe_o, 1);
        rd(3'd4, v); chk("R5", "count wrapped", v, 0);
        step(1);
        chk("R5", "strobe one cycle", rst_strobe_o, 0);
        rd(3'd4, v); chk("R5", "count restarts", v, 1);
        step(8);

        // R6 clear behaviour
        cur_req = "R6";
        wr_reg(3'd1, 16'h0000, 0);
        rd(3'd0, v); chk("R6", "zero clear ignored", v, 3);
        fail_i = 2'b01;
        wr_reg(3'd1, 16'h0002, 0);
        fail_i = 2'b00;
        rd(3'd0, v); chk("R6", "set wins over clear", v, 3);
        wr_reg(3'd1, 16'h0002, 0);
        chk("R6", "nmi_o dropped", nmi_o, 0);
        step(1);
        rd(3'd4, v); chk("R6", "count zero after clear", v, 0);
        step(2);

        // R7 force register
        cur_req = "R7";
        wr_reg(3'd2, 16'h0000, 1);
        rd(3'd0, v); chk("R7", "force zero ignored", v, 0);
        rd(3'd2, v); chk("R7", "force reads zero", v, 0);
        wr_reg(3'd2, 16'h0002, 1);
        rd(3'd0, v); chk("R7", "force sets clock-fail", v, 3);
        rd(3'd2, v); chk("R7", "force reads zero after set", v, 0);
        chk("R7", "nmi_o from force", nmi_o, 1);
        step(12);
        wr_reg(3'd3, 16'd2, 1);
        step(10);
        wr_reg(3'd1, 16'h0002, 0);
        step(3);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run is a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL %s watchdog actual=running expected=finished", cur_req);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule